// File: doc/BRIEF.md
# Dual-Mode Host Parallel Bus Interface

This block is the device side of a 16-bit asynchronous parallel host bus. A host processor uses it to push command and data words into the chip and to fetch words that the chip has prepared. One protocol input picks the bus flavour. The 6800-style flavour uses an enable strobe and a direction line. The 8080-style flavour uses separate active-low read and write strobes. Two active-low select inputs qualify every access, and a tag line marks each access as a command or a data word.

All host-side controls and the bus value cross into the block's clock through a two-stage synchronizer. Edges are detected after that crossing. Each write that completes becomes a 17-bit word on a valid/ready output: the tag sits above the sixteen data bits. An internal source loads a return word, which raises an interrupt towards the host. The bus is driven with that word only during a qualified read. The interrupt drops when the host finishes its second read after the load. An active-high `awake` input acts as a power switch: when it is low, the block goes quiet.

Top module: `hostbus_if`

## Requirements
- R1: `proto_sel` = 1 selects 8080-style timing and 0 selects 6800-style timing. The value only takes effect while both select inputs are high (deselected), so a change during an access is ignored until that access ends.
- R2: In 6800-style timing, `strb_b` is the direction line (1 = read, 0 = write). A write is captured when `strb_a` (enable) falls while the device is selected.
- R3: In 6800-style timing with `strb_a` held high for the whole access, a write is captured when the select ends (the rising edge that deselects the device).
- R4: In 8080-style timing, `strb_b` is the active-low write strobe. A write is captured on whichever comes first: the rise of `strb_b` or the end of the select. There is exactly one capture per access, so bus changes between the two edges are not taken.
- R5: In 8080-style timing, `bus_oe` is high only while `strb_a` (active-low read strobe) is low and the device is selected. In 6800-style timing, `bus_oe` is high only while selected, with direction = read and enable high. At all other times `bus_oe` is low.
- R6: The captured word is `{tag, data}`: bit 16 holds `tag_in` (1 = data word, 0 = command word) and bits 15:0 hold `bus_in`.
- R7: The device counts as selected only when both `sel_a_n` and `sel_b_n` are low. An access with only one of them low captures nothing and never drives the bus.
- R8: `wr_valid` stays high and `wr_word` stays stable until a cycle with `wr_ready` high. That cycle accepts the word, and `wr_valid` drops unless a new write is captured in the same cycle.
- R9: A write that completes while an unaccepted word is pending is dropped. The pending word is kept and `wr_ovf` is set and stays set until reset.
- R10: `rd_irq` rises the cycle after `rd_load` and drops when the second host read after that load completes. A load in the same cycle as a read completion wins: the interrupt stays high and the read count restarts.
- R11: While `awake` is low, `bus_oe` is low and no write is captured. One cycle later, `rd_irq` and `wr_valid` are low.
- R12: After reset, `wr_valid`, `wr_ovf`, `rd_irq` and `bus_oe` are low and the protocol is 6800-style.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| awake | input | 1 | Low = power-down |
| proto_sel | input | 1 | 1 = 8080-style, 0 = 6800-style |
| strb_a | input | 1 | Enable (6800) or active-low read strobe (8080) |
| strb_b | input | 1 | Direction (6800, 1 = read) or active-low write strobe (8080) |
| sel_a_n | input | 1 | First active-low select |
| sel_b_n | input | 1 | Second active-low select |
| tag_in | input | 1 | 1 = data word, 0 = command word |
| bus_in | input | 16 | Bus value from the host |
| bus_out | output | 16 | Return word towards the host |
| bus_oe | output | 1 | Bus drive enable |
| wr_valid | output | 1 | Captured word pending |
| wr_ready | input | 1 | Consumer accepts the pending word |
| wr_word | output | 17 | Captured `{tag, data}` |
| wr_ovf | output | 1 | Sticky dropped-write flag |
| rd_load | input | 1 | Load a return word |
| rd_data | input | 16 | Return word from the internal source |
| rd_irq | output | 1 | Return word ready for the host |

## Verification
Two pairs of events can land in the same clock cycle. The first pair is the completion of the host's second read and a fresh `rd_load`. The bench times the load pulse to the exact cycle in which the synchronized read strobe rises. It then expects the interrupt to stay high and to need two more reads before it drops. The second pair is a write capture while a word is still pending. The bench holds `wr_ready` low across two writes and judges that the first word survives unchanged and the overflow flag is set.

// File: rtl/hostbus_pkg.sv
package hostbus_pkg;

  typedef enum logic {
    PROTO_M68 = 1'b0,
    PROTO_I80 = 1'b1
  } proto_e;

  // device counts as selected only when both active-low selects are low
  function automatic logic both_low(input logic a_n, input logic b_n);
    return ~a_n & ~b_n;
  endfunction

  function automatic logic rose(input logic prev, input logic now);
    return ~prev & now;
  endfunction

  function automatic logic fell(input logic prev, input logic now);
    return prev & ~now;
  endfunction

endpackage

// File: rtl/hostbus_sync.sv
module hostbus_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= RST_VAL;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/hostbus_strobe.sv
module hostbus_strobe
  import hostbus_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   pd,
  input  proto_e proto,
  input  logic   s_a,
  input  logic   s_b,
  input  logic   s_sel_a_n,
  input  logic   s_sel_b_n,
  output logic   wr_evt,
  output logic   rd_evt,
  output logic   drive,
  output logic   idle,
  output logic   sel_now
);

  logic p_a, p_b, p_sel_a_n, p_sel_b_n;
  logic sel_was, sel_end, a_steady_hi;
  logic m68_wr, m68_rd, i80_wr, i80_rd;
  logic wr_arm, rd_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p_a       <= 1'b1;
      p_b       <= 1'b1;
      p_sel_a_n <= 1'b1;
      p_sel_b_n <= 1'b1;
    end else begin
      p_a       <= s_a;
      p_b       <= s_b;
      p_sel_a_n <= s_sel_a_n;
      p_sel_b_n <= s_sel_b_n;
    end
  end

  assign sel_now     = both_low(s_sel_a_n, s_sel_b_n);
  assign sel_was     = both_low(p_sel_a_n, p_sel_b_n);
  assign sel_end     = fell(sel_was, sel_now);
  assign a_steady_hi = p_a & s_a;
  assign idle        = s_sel_a_n & s_sel_b_n;

  // 6800 style: enable falling edge, or select end with enable parked high
  assign m68_wr = (sel_was & fell(p_a, s_a) & ~p_b) | (sel_end & a_steady_hi & ~p_b);
  assign m68_rd = (sel_was & fell(p_a, s_a) &  p_b) | (sel_end & a_steady_hi &  p_b);

  // 8080 style: first of strobe rise or select end, once per access
  assign i80_wr = wr_arm & (rose(p_b, s_b) | sel_end);
  assign i80_rd = rd_arm & (rose(p_a, s_a) | sel_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_arm <= 1'b0;
      rd_arm <= 1'b0;
    end else if (pd || proto != PROTO_I80) begin
      wr_arm <= 1'b0;
      rd_arm <= 1'b0;
    end else begin
      wr_arm <= i80_wr ? 1'b0 : (wr_arm | (sel_now & ~s_b));
      rd_arm <= i80_rd ? 1'b0 : (rd_arm | (sel_now & ~s_a));
    end
  end

  always_comb begin
    if (proto == PROTO_I80) begin
      wr_evt = i80_wr;
      rd_evt = i80_rd;
      drive  = sel_now & ~s_a;
    end else begin
      wr_evt = m68_wr;
      rd_evt = m68_rd;
      drive  = sel_now & s_b & s_a;
    end
    if (pd) begin
      wr_evt = 1'b0;
      rd_evt = 1'b0;
      drive  = 1'b0;
    end
  end

endmodule

// File: rtl/hostbus_wrq.sv
module hostbus_wrq #(
  parameter int unsigned WORD_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd,
  input  logic              cap,
  input  logic [WORD_W-1:0] cap_word,
  input  logic              ready,
  output logic              valid,
  output logic [WORD_W-1:0] word,
  output logic              ovf,
  output logic              drop
);

  logic accept, room;

  assign accept = valid & ready;
  assign room   = ~valid | accept;
  assign drop   = cap & ~room;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      word  <= '0;
      ovf   <= 1'b0;
    end else begin
      if (pd)                valid <= 1'b0;
      else if (cap && room)  valid <= 1'b1;
      else if (accept)       valid <= 1'b0;
      if (!pd && cap && room) word <= cap_word;
      if (drop) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/hostbus_rdret.sv
module hostbus_rdret #(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CLEAR_AFTER = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pd,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rd_done,
  output logic              irq,
  output logic [DATA_W-1:0] hold
);

  localparam int unsigned CW = $clog2(CLEAR_AFTER + 1);
  localparam logic [CW-1:0] LAST = CW'(CLEAR_AFTER - 1);

  logic [CW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq  <= 1'b0;
      seen <= '0;
      hold <= '0;
    end else if (pd) begin
      irq  <= 1'b0;
      seen <= '0;
    end else if (load) begin
      irq  <= 1'b1;
      seen <= '0;
      hold <= load_data;
    end else if (rd_done && irq) begin
      if (seen == LAST) begin
        irq  <= 1'b0;
        seen <= '0;
      end else begin
        seen <= seen + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hostbus_if.sv
module hostbus_if
  import hostbus_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awake,
  input  logic              proto_sel,
  input  logic              strb_a,
  input  logic              strb_b,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              tag_in,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [DATA_W:0]   wr_word,
  output logic              wr_ovf,
  input  logic              rd_load,
  input  logic [DATA_W-1:0] rd_data,
  output logic              rd_irq
);

  localparam int unsigned CTL_W  = 6;
  localparam int unsigned WORD_W = DATA_W + 1;

  logic [CTL_W-1:0]  ctl_raw, ctl_s;
  logic [DATA_W-1:0] bus_s;
  logic              s_mode, s_tag, s_sel_b_n, s_sel_a_n, s_b, s_a;
  logic              pd, idle, sel_now;
  logic              cap_evt, rd_evt, bus_drive, drop_evt;
  proto_e            proto_q;

  assign pd      = ~awake;
  assign ctl_raw = {proto_sel, tag_in, sel_b_n, sel_a_n, strb_b, strb_a};

  hostbus_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_ctl_sync (
    .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
  );

  hostbus_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d(bus_in), .q(bus_s)
  );

  assign {s_mode, s_tag, s_sel_b_n, s_sel_a_n, s_b, s_a} = ctl_s;

  // protocol only follows the input between accesses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    proto_q <= PROTO_M68;
    else if (idle) proto_q <= proto_e'(s_mode);
  end

  hostbus_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .pd(pd), .proto(proto_q),
    .s_a(s_a), .s_b(s_b), .s_sel_a_n(s_sel_a_n), .s_sel_b_n(s_sel_b_n),
    .wr_evt(cap_evt), .rd_evt(rd_evt), .drive(bus_drive),
    .idle(idle), .sel_now(sel_now)
  );

  hostbus_wrq #(.WORD_W(WORD_W)) u_wrq (
    .clk(clk), .rst_n(rst_n), .pd(pd), .cap(cap_evt),
    .cap_word({s_tag, bus_s}), .ready(wr_ready),
    .valid(wr_valid), .word(wr_word), .ovf(wr_ovf), .drop(drop_evt)
  );

  hostbus_rdret #(.DATA_W(DATA_W), .CLEAR_AFTER(2)) u_rdret (
    .clk(clk), .rst_n(rst_n), .pd(pd), .load(rd_load), .load_data(rd_data),
    .rd_done(rd_evt), .irq(rd_irq), .hold(bus_out)
  );

  assign bus_oe = bus_drive & awake & sel_now;

endmodule

// File: rtl/hostbus_if_chk.sv
module hostbus_if_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            awake,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic [DATA_W:0] wr_word,
  input logic            wr_ovf,
  input logic            rd_load,
  input logic            rd_irq,
  input logic            cap_evt,
  input logic            drop_evt
);

  p_hold_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready && awake |=> wr_valid && $stable(wr_word));

  p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ovf |=> wr_ovf);

  p_busy_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt && wr_valid && !wr_ready |=> wr_ovf);

  p_drop_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> wr_valid && $stable(wr_word));

  p_single_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> !cap_evt);

  p_irq_on_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_load && awake |=> rd_irq);

  p_sleep_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !awake |=> !rd_irq && !wr_valid);

endmodule

bind hostbus_if hostbus_if_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .awake(awake), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_word(wr_word), .wr_ovf(wr_ovf),
  .rd_load(rd_load), .rd_irq(rd_irq), .cap_evt(cap_evt), .drop_evt(drop_evt)
);

// File: tb/hostbus_if_bench.sv
module hostbus_if_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        awake = 1'b1;
  logic        proto_sel = 1'b0;
  logic        strb_a = 1'b0;
  logic        strb_b = 1'b1;
  logic        sel_a_n = 1'b1;
  logic        sel_b_n = 1'b1;
  logic        tag_in = 1'b1;
  logic [15:0] bus_in = '0;
  logic [15:0] bus_out;
  logic        bus_oe;
  logic        wr_valid;
  logic        wr_ready = 1'b0;
  logic [16:0] wr_word;
  logic        wr_ovf;
  logic        rd_load = 1'b0;
  logic [15:0] rd_data = '0;
  logic        rd_irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  hostbus_if u_hostbus_if (
    .clk(clk), .rst_n(rst_n), .awake(awake), .proto_sel(proto_sel),
    .strb_a(strb_a), .strb_b(strb_b), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .tag_in(tag_in), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_word(wr_word), .wr_ovf(wr_ovf),
    .rd_load(rd_load), .rd_data(rd_data), .rd_irq(rd_irq)
  );

  function automatic logic [16:0] exp_word(input logic tag, input logic [15:0] d);
    return {tag, d};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input logic [1:0] m);
    sel_a_n = ~m[0];
    sel_b_n = ~m[1];
  endtask

  task automatic set_proto(input logic p);
    set_sel(2'b00);
    proto_sel = p;
    if (p) begin strb_a = 1'b1; strb_b = 1'b1; end
    else   begin strb_a = 1'b0; strb_b = 1'b1; end
    wt(5);
  endtask

  // 8080-style write; cs_first ends the select before the write strobe
  task automatic w80(input logic tag, input logic [15:0] d, input bit cs_first, input logic [1:0] m);
    strb_a = 1'b1; strb_b = 1'b1; tag_in = tag; bus_in = d;
    set_sel(m); wt(4);
    strb_b = 1'b0; wt(4);
    if (cs_first) begin
      set_sel(2'b00); wt(4);
      bus_in = ~d; tag_in = ~tag;
      strb_b = 1'b1; wt(4);
    end else begin
      strb_b = 1'b1; wt(4);
      bus_in = ~d; tag_in = ~tag;
      set_sel(2'b00); wt(4);
    end
  endtask

  // 6800-style write; e_static parks enable high for the whole access
  task automatic w68(input logic tag, input logic [15:0] d, input bit e_static, input logic [1:0] m);
    strb_b = 1'b0; tag_in = tag; bus_in = d;
    strb_a = e_static;
    wt(4);
    set_sel(m); wt(4);
    if (!e_static) begin
      strb_a = 1'b1; wt(4);
      strb_a = 1'b0; wt(4);
      bus_in = ~d; tag_in = ~tag; wt(4);
      set_sel(2'b00); wt(4);
    end else begin
      set_sel(2'b00); wt(4);
      bus_in = ~d; tag_in = ~tag;
      strb_a = 1'b0; wt(4);
    end
    strb_b = 1'b1;
  endtask

  task automatic rd80(input logic [15:0] exp, input string req);
    strb_a = 1'b1; strb_b = 1'b1;
    set_sel(2'b11); wt(4);
    chk(bus_oe == 1'b0, "R5 released before read strobe", 32'(bus_oe), 0);
    strb_a = 1'b0; wt(4);
    chk(bus_oe == 1'b1 && bus_out == exp, req, {15'd0, bus_oe, bus_out}, {16'd1, exp});
    strb_a = 1'b1; wt(4);
    chk(bus_oe == 1'b0, "R5 released after read strobe", 32'(bus_oe), 0);
    set_sel(2'b00); wt(4);
  endtask

  task automatic rd68(input logic [15:0] exp, input string req);
    strb_a = 1'b0; strb_b = 1'b1;
    set_sel(2'b11); wt(4);
    strb_a = 1'b1; wt(4);
    chk(bus_oe == 1'b1 && bus_out == exp, req, {15'd0, bus_oe, bus_out}, {16'd1, exp});
    strb_a = 1'b0; wt(4);
    chk(bus_oe == 1'b0, "R5 released after enable", 32'(bus_oe), 0);
    set_sel(2'b00); wt(4);
  endtask

  task automatic expect_word(input logic [16:0] exp, input string req);
    chk(wr_valid == 1'b1 && wr_word == exp, req, {15'd0, wr_valid, wr_word[15:0]} | (32'(wr_word[16]) << 17), {15'd0, 1'b1, exp[15:0]} | (32'(exp[16]) << 17));
    wr_ready = 1'b1; wt(1);
    wr_ready = 1'b0; wt(1);
    chk(wr_valid == 1'b0, "R8 valid drops after accept", 32'(wr_valid), 0);
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic        tg;
    bit          pr, sty;
    void'($urandom(32'h5eed_1234));

    wt(3);
    chk(wr_valid == 0 && wr_ovf == 0 && rd_irq == 0 && bus_oe == 0, "R12 reset state",
        {wr_valid, wr_ovf, rd_irq, bus_oe}, 0);
    rst_n = 1'b1; wt(4);

    // R2: enable-fall write in default 6800-style mode (also R12 default protocol)
    w68(1'b1, 16'hA55A, 1'b0, 2'b11);
    expect_word(exp_word(1'b1, 16'hA55A), "R2 enable fall capture");
    // R3 with command tag (R6)
    w68(1'b0, 16'h1234, 1'b1, 2'b11);
    expect_word(exp_word(1'b0, 16'h1234), "R3 R6 select end capture");

    // R1: protocol change inside an access is ignored
    strb_b = 1'b0; strb_a = 1'b0; tag_in = 1'b1; bus_in = 16'h0F0F; wt(4);
    set_sel(2'b11); wt(4);
    proto_sel = 1'b1; wt(4);
    strb_a = 1'b1; wt(4);
    strb_a = 1'b0; wt(4);
    bus_in = 16'hF0F0; wt(4);
    set_sel(2'b00); wt(4);
    expect_word(exp_word(1'b1, 16'h0F0F), "R1 mode held during access");
    proto_sel = 1'b0; strb_b = 1'b1; wt(5);

    // R4: 8080 both orderings
    set_proto(1'b1);
    w80(1'b1, 16'hBEEF, 1'b0, 2'b11);
    expect_word(exp_word(1'b1, 16'hBEEF), "R4 write strobe first");
    w80(1'b0, 16'hC0DE, 1'b1, 2'b11);
    expect_word(exp_word(1'b0, 16'hC0DE), "R4 select end first");
    wt(4);
    chk(wr_valid == 1'b0, "R4 one capture per access", 32'(wr_valid), 0);

    // R7: single select never captures
    w80(1'b1, 16'h7777, 1'b0, 2'b01);
    chk(wr_valid == 1'b0, "R7 only first select low", 32'(wr_valid), 0);
    w80(1'b1, 16'h6666, 1'b1, 2'b10);
    chk(wr_valid == 1'b0, "R7 only second select low", 32'(wr_valid), 0);

    // R5: read strobe low without selection
    strb_a = 1'b0; set_sel(2'b01); wt(4);
    chk(bus_oe == 1'b0, "R5 R7 no drive when half selected", 32'(bus_oe), 0);
    strb_a = 1'b1; set_sel(2'b00); wt(4);

    // R8 R9: overflow
    w80(1'b1, 16'h1111, 1'b0, 2'b11);
    w80(1'b1, 16'h2222, 1'b0, 2'b11);
    chk(wr_ovf == 1'b1, "R9 overflow set", 32'(wr_ovf), 1);
    expect_word(exp_word(1'b1, 16'h1111), "R8 R9 first word kept");
    wt(4);
    chk(wr_ovf == 1'b1, "R9 overflow sticky", 32'(wr_ovf), 1);

    // R10: interrupt and second-read clear, 8080 style
    @(negedge clk); rd_data = 16'h5A5A; rd_load = 1'b1;
    @(negedge clk); rd_load = 1'b0;
    chk(rd_irq == 1'b1, "R10 irq after load", 32'(rd_irq), 1);
    rd80(16'h5A5A, "R5 R10 read returns word");
    chk(rd_irq == 1'b1, "R10 irq after first read", 32'(rd_irq), 1);
    rd80(16'h5A5A, "R5 R10 second read");
    chk(rd_irq == 1'b0, "R10 irq cleared on second read", 32'(rd_irq), 0);

    // R10 collision: load in the cycle the second read completes
    @(negedge clk); rd_data = 16'h0101; rd_load = 1'b1;
    @(negedge clk); rd_load = 1'b0;
    rd80(16'h0101, "R10 collision read one");
    strb_a = 1'b1; set_sel(2'b11); wt(4);
    strb_a = 1'b0; wt(4);
    strb_a = 1'b1;
    @(negedge clk); @(negedge clk);
    rd_data = 16'h0202; rd_load = 1'b1;
    @(negedge clk); rd_load = 1'b0;
    wt(3); set_sel(2'b00); wt(4);
    chk(rd_irq == 1'b1, "R10 load wins over second read", 32'(rd_irq), 1);
    rd80(16'h0202, "R10 new word after collision");
    chk(rd_irq == 1'b1, "R10 count restarted", 32'(rd_irq), 1);
    rd80(16'h0202, "R10 second read after collision");
    chk(rd_irq == 1'b0, "R10 cleared after restart", 32'(rd_irq), 0);

    // R11: power-down during read with pending word
    w80(1'b0, 16'h3333, 1'b0, 2'b11);
    @(negedge clk); rd_data = 16'h4444; rd_load = 1'b1;
    @(negedge clk); rd_load = 1'b0;
    strb_a = 1'b1; set_sel(2'b11); wt(4);
    strb_a = 1'b0; wt(4);
    chk(bus_oe == 1'b1, "R5 driving before power-down", 32'(bus_oe), 1);
    awake = 1'b0; #1;
    chk(bus_oe == 1'b0, "R11 bus released", 32'(bus_oe), 0);
    wt(2);
    chk(rd_irq == 1'b0 && wr_valid == 1'b0, "R11 irq and word cleared", {rd_irq, wr_valid}, 0);
    strb_a = 1'b1; set_sel(2'b00); wt(4);
    awake = 1'b1; wt(4);

    // R2 R5: 6800 read
    set_proto(1'b0);
    @(negedge clk); rd_data = 16'h9876; rd_load = 1'b1;
    @(negedge clk); rd_load = 1'b0;
    rd68(16'h9876, "R2 R5 6800 read");
    rd68(16'h9876, "R2 6800 second read");
    chk(rd_irq == 1'b0, "R10 6800 irq clear", 32'(rd_irq), 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      pr  = 1'($urandom);
      sty = 1'($urandom);
      tg  = 1'($urandom);
      d   = 16'($urandom);
      set_proto(pr);
      if (pr) begin
        w80(tg, d, sty, 2'b11);
        expect_word(exp_word(tg, d), "R4 R6 random 8080 write");
      end else begin
        w68(tg, d, sty, 2'b11);
        expect_word(exp_word(tg, d), sty ? "R3 R6 random 6800 write" : "R2 R6 random 6800 write");
      end
    end

    finish_run();
  end

endmodule